// File: doc/BRIEF.md
# Shared Doorbell Pending Register

This block holds one doorbell-pending flag for each hardware thread of a multithreaded core. All threads see them as one register. A read gathers every flag into one word, with bit N standing for thread N. A write sets or clears every thread's flag at once from the matching bits of the written value. Other logic can raise a thread's flag with `db_set` or drop it with `db_clr`. Delivery of the interrupt itself happens elsewhere; it only sees the `pending` vector.

A mode input gives each thread a private one-bit view, for use when every thread runs in its own partition. In that mode, bit 0 of a read is the requester's own flag. A write changes only the requester's flag, from bit 0 of the value.

Every access passes through a hypervisor facility gate. The gate blocks an access when all three of these hold:
- the core implements hypervisor mode;
- the requester is not in hypervisor state;
- the message-facility enable is clear.

A blocked access changes nothing. Instead it raises a facility-unavailable exception and asks for the interruption-cause field of the hypervisor facility control register to be cleared.

Top module: `doorbell_status_reg`

## Requirements
- R1: After reset, `pending` is all zero, and `rd_valid`, `hv_fac_unavail` and `hfac_cause_clr` are low.
- R2: In shared mode (`single_thread_mode`=0), a permitted read strobe gives `rd_valid`=1 one cycle later. In that same cycle, `rd_data` bit N equals thread N's flag, and every bit at index NTHREADS or above is zero.
- R3: In shared mode, a permitted write loads every thread's flag N from `acc_wdata` bit N at the next clock edge. Bits of `acc_wdata` at index NTHREADS and above have no effect.
- R4: In private mode (`single_thread_mode`=1), a permitted read returns the flag of thread `acc_tid` in bit 0 of `rd_data`, and zero in every other bit.
- R5: In private mode, a permitted write loads only thread `acc_tid`'s flag, from `acc_wdata` bit 0. Every other flag keeps its value.
- R6: When `hv_capable`=1, `hv_state`=0 and `msg_fac_en`=0, an access is blocked. A blocked read or write changes no flag and produces no `rd_valid`. It pulses `hv_fac_unavail` for one cycle, one cycle after the strobe.
- R7: `hfac_cause_clr` pulses in exactly the cycles in which `hv_fac_unavail` pulses.
- R8: If `hv_capable`=0, `hv_state`=1 or `msg_fac_en`=1, the access completes normally and `hv_fac_unavail` stays low.
- R9: If a permitted write and a `db_set` bit target the same thread in the same cycle, that thread takes the written value.
- R10: For a thread that is not being written, `db_set` sets its flag and `db_clr` clears it. When both are asserted together, set wins. With neither asserted, the flag holds.
- R11: When a read and a write arrive in the same cycle, the read returns the flags as they were before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_thread_mode | input | 1 | 1 = private one-bit view per thread |
| hv_capable | input | 1 | Core implements hypervisor mode |
| hv_state | input | 1 | Requester runs in hypervisor state |
| msg_fac_en | input | 1 | Message-facility enable bit from the hypervisor facility control register |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_tid | input | TID_W | Thread id of the requester |
| acc_wdata | input | DATA_W | Write value |
| db_set | input | NTHREADS | Per-thread doorbell raise |
| db_clr | input | NTHREADS | Per-thread doorbell drop |
| pending | output | NTHREADS | Per-thread doorbell-pending flags |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a permitted read |
| hv_fac_unavail | output | 1 | Facility-unavailable exception pulse |
| hfac_cause_clr | output | 1 | Request to clear the interruption-cause field |

## Verification
The hardest case to reach is the one where several sources contend for the same flag in one cycle: a write against `db_set`, a set against a clear, or a read against a write. Each of these needs two strobes lined up on the same clock edge. The bench produces them by driving both inputs on the same falling edge, with the flags preloaded to a known pattern beforehand. In private mode, the bench sweeps every requester id against every preloaded pattern, so that the unwritten threads are seen to hold. It also sweeps all eight settings of the three gate inputs.

// File: rtl/doorbell_status_reg.sv
module doorbell_status_reg #(
  parameter int NTHREADS = 4,
  parameter int DATA_W   = 64,
  localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                single_thread_mode,
  input  logic                hv_capable,
  input  logic                hv_state,
  input  logic                msg_fac_en,
  input  logic                acc_rd,
  input  logic                acc_wr,
  input  logic [TID_W-1:0]    acc_tid,
  input  logic [DATA_W-1:0]   acc_wdata,
  input  logic [NTHREADS-1:0] db_set,
  input  logic [NTHREADS-1:0] db_clr,
  output logic [NTHREADS-1:0] pending,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_valid,
  output logic                hv_fac_unavail,
  output logic                hfac_cause_clr
);

  logic                blocked, rd_ok, wr_ok;
  logic [NTHREADS-1:0] wr_mask, wr_val, pend_q, pend_d;
  logic [DATA_W-1:0]   rd_word;
  logic                unused_wdata_hi;

  assign blocked = hv_capable & ~hv_state & ~msg_fac_en;
  assign rd_ok   = acc_rd & ~blocked;
  assign wr_ok   = acc_wr & ~blocked;
  assign unused_wdata_hi = ^acc_wdata[DATA_W-1:NTHREADS];

  always_comb begin
    wr_mask = '0;
    wr_val  = '0;
    if (wr_ok) begin
      if (single_thread_mode) begin
        wr_mask[acc_tid] = 1'b1;
        wr_val           = {NTHREADS{acc_wdata[0]}};
      end else begin
        wr_mask = '1;
        wr_val  = acc_wdata[NTHREADS-1:0];
      end
    end
  end

  for (genvar g = 0; g < NTHREADS; g++) begin : g_thr
    assign pend_d[g] = wr_mask[g] ? wr_val[g]
                                  : (db_set[g] | (pend_q[g] & ~db_clr[g]));
  end

  always_comb begin
    rd_word = '0;
    if (single_thread_mode) rd_word[0] = pend_q[acc_tid];
    else                    rd_word[NTHREADS-1:0] = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q         <= '0;
      rd_data        <= '0;
      rd_valid       <= 1'b0;
      hv_fac_unavail <= 1'b0;
    end else begin
      pend_q         <= pend_d;
      rd_valid       <= rd_ok;
      hv_fac_unavail <= blocked & (acc_rd | acc_wr);
      if (rd_ok) rd_data <= rd_word;
    end
  end

  assign pending        = pend_q;
  assign hfac_cause_clr = hv_fac_unavail;

  p_rvalid_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_rd) && !$past(blocked));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[DATA_W-1:NTHREADS] == '0));

  p_shared_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !blocked && !single_thread_mode) |=> (pending == $past(acc_wdata[NTHREADS-1:0])));

  p_private_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !blocked && single_thread_mode) |=> (rd_data[DATA_W-1:1] == '0));

  p_blocked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && blocked && db_set == '0 && db_clr == '0) |=> $stable(pending));

  p_blocked_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hv_fac_unavail |-> !rd_valid);

  p_exc_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hv_fac_unavail |-> $past(blocked));

endmodule

// File: tb/sim_doorbell_status_reg.sv
module sim_doorbell_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        single_thread_mode = 1'b0;
  logic        hv_capable = 1'b0, hv_state = 1'b0, msg_fac_en = 1'b0;
  logic        acc_rd = 1'b0, acc_wr = 1'b0;
  logic [1:0]  acc_tid = '0;
  logic [63:0] acc_wdata = '0;
  logic [3:0]  db_set = '0, db_clr = '0;
  logic [3:0]  pending;
  logic [63:0] rd_data;
  logic        rd_valid, hv_fac_unavail, hfac_cause_clr;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  doorbell_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .single_thread_mode(single_thread_mode),
    .hv_capable(hv_capable), .hv_state(hv_state), .msg_fac_en(msg_fac_en),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_tid(acc_tid), .acc_wdata(acc_wdata),
    .db_set(db_set), .db_clr(db_clr), .pending(pending), .rd_data(rd_data),
    .rd_valid(rd_valid), .hv_fac_unavail(hv_fac_unavail), .hfac_cause_clr(hfac_cause_clr));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [63:0] v, input logic [1:0] t);
    @(negedge clk); acc_wr = 1'b1; acc_wdata = v; acc_tid = t;
    @(negedge clk); acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] t);
    @(negedge clk); acc_rd = 1'b1; acc_tid = t;
    @(negedge clk); acc_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] e;
    repeat (3) @(negedge clk);
    chk("R1 pending", pending, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 exc", {hv_fac_unavail, hfac_cause_clr}, 0);
    rst_n = 1'b1;

    for (int p = 0; p < 16; p++) begin
      wr({60'hA5A5_5A5A_F0F0_0F0, 4'(p)}, 2'(p));
      chk("R3 shared write", pending, 64'(p));
      rd(2'(p));
      chk("R2 shared read valid", rd_valid, 1);
      chk("R2 shared read data", rd_data, 64'(p));
    end

    for (int t = 0; t < 4; t++) begin
      for (int b = 0; b < 16; b++) begin
        logic bit_v;
        single_thread_mode = 1'b0;
        wr(64'(b), 2'd0);
        single_thread_mode = 1'b1;
        bit_v = ~b[t];
        wr({63'h7FFF_FFFF_FFFF_FFFF, bit_v}, 2'(t));
        e = 4'(b);
        e[t] = bit_v;
        chk("R5 private write", pending, 64'(e));
        rd(2'(t));
        chk("R4 private read", {rd_valid, rd_data}, {1'b1, 63'd0, bit_v});
      end
    end
    single_thread_mode = 1'b0;

    for (int g = 0; g < 8; g++) begin
      logic blk;
      hv_capable = 1'b0; hv_state = 1'b0; msg_fac_en = 1'b0;
      wr(64'h5, 2'd0);
      hv_capable = g[2]; hv_state = g[1]; msg_fac_en = g[0];
      blk = g[2] & ~g[1] & ~g[0];
      @(negedge clk); acc_wr = 1'b1; acc_wdata = 64'hA;
      @(negedge clk); acc_wr = 1'b0;
      chk(blk ? "R6 blocked write exc" : "R8 open write exc", hv_fac_unavail, 64'(blk));
      chk("R7 cause clear on write", hfac_cause_clr, 64'(blk));
      chk(blk ? "R6 blocked write hold" : "R8 open write", pending, blk ? 64'h5 : 64'hA);
      rd(2'd0);
      chk(blk ? "R6 blocked read valid" : "R8 open read valid", rd_valid, 64'(!blk));
      chk("R7 cause clear on read", {hv_fac_unavail, hfac_cause_clr}, blk ? 64'd3 : 64'd0);
      if (!blk) chk("R8 open read data", rd_data, 64'hA);
      @(negedge clk);
      chk("R6 exc single pulse", hv_fac_unavail, 0);
    end
    hv_capable = 1'b0; hv_state = 1'b0; msg_fac_en = 1'b0;

    wr(64'h0, 2'd0);
    @(negedge clk); db_set = 4'b0011;
    @(negedge clk); db_set = '0;
    chk("R10 set", pending, 64'h3);
    @(negedge clk); db_clr = 4'b0001;
    @(negedge clk); db_clr = '0;
    chk("R10 clear", pending, 64'h2);
    @(negedge clk); db_set = 4'b0100; db_clr = 4'b0100;
    @(negedge clk); db_set = '0; db_clr = '0;
    chk("R10 set beats clear", pending, 64'h6);
    repeat (3) @(negedge clk);
    chk("R10 hold", pending, 64'h6);

    wr(64'h0, 2'd0);
    @(negedge clk); acc_wr = 1'b1; acc_wdata = 64'h0; db_set = 4'hF;
    @(negedge clk); acc_wr = 1'b0; db_set = '0;
    chk("R9 shared write beats set", pending, 64'h0);
    single_thread_mode = 1'b1;
    @(negedge clk); acc_wr = 1'b1; acc_wdata = 64'h0; acc_tid = 2'd2; db_set = 4'b0101;
    @(negedge clk); acc_wr = 1'b0; db_set = '0;
    chk("R9 private write beats set", pending, 64'h1);
    single_thread_mode = 1'b0;

    wr(64'h9, 2'd0);
    @(negedge clk); acc_rd = 1'b1; acc_wr = 1'b1; acc_wdata = 64'h6;
    @(negedge clk); acc_rd = 1'b0; acc_wr = 1'b0;
    chk("R11 read old value", rd_data, 64'h9);
    chk("R11 write applied", pending, 64'h6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule